// File: doc/BRIEF.md
# Three-Phase Shunt Sampling Trigger Calculator

This block works out when an ADC conversion should start within a PWM period, so that low-side shunt currents are sampled while the low-side switches conduct. For every phase it receives two compare values: the value waiting to be loaded (pending) and the value now in force (active). It also receives the falling-edge dead-band delay, a flag that says whether all three shunts may be used, and a code that names the phase with the middle output voltage.

From these inputs it picks one reference phase. When all shunts are usable, the reference is the phase whose estimated next pulse is shortest. Otherwise the reference is the middle-voltage phase. The block then derives a new compare B value and the count direction on which the conversion start should fire. The result always goes to the first phase's timer.

The calculation is purely combinational. It is captured into output registers on a start strobe, and a done flag marks the new result.

Top module: `adc_trig_calc`

## Requirements
- R1: After reset, `cmpB` is 0, `socOnDown` is 0 and `done` is 0.
- R2: For each phase, the estimated pulse is (pending + active) / 2. The sum is taken at 17 bits and the division truncates.
- R3: When `allShunts` is 1, the reference is the phase with the smallest estimated pulse. On a tie, phase 1 wins over phase 2, and phase 2 wins over phase 3.
- R4: When `allShunts` is 0, `midPhase` selects the reference: 0 selects phase 1, 1 selects phase 2, 2 selects phase 3, and the unused code 3 also selects phase 3.
- R5: If the reference's active value is at least its pending value plus `deadFall`, then `cmpB` = (active − (pending + deadFall)) / 2 + 1 and `socOnDown` = 1 (fire while counting down).
- R6: Otherwise, `cmpB` = ((pending + deadFall) − active) / 2 + 1, taken modulo 2^16, and `socOnDown` = 0 (fire while counting up).
- R7: The sum pending + `deadFall` is formed at 17 bits, so a carry out of 16 bits is kept in the comparison and in the difference.
- R8: `cmpB` and `socOnDown` load only on a clock edge at which `start` is 1. At every other edge they hold, whatever the inputs do.
- R9: `done` is 1 for exactly the cycle that follows a cycle with `start` high, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture strobe |
| allShunts | input | 1 | 1 = all three shunts usable |
| midPhase | input | 2 | Middle-voltage phase code (0,1,2; 3 treated as 2) |
| pendCmp | input | 3x16 | Pending compare A per phase, index 0 = phase 1 |
| actCmp | input | 3x16 | Active compare A per phase, index 0 = phase 1 |
| deadFall | input | 16 | Falling-edge dead-band delay in counts |
| cmpB | output | 16 | New compare B value for phase 1 |
| socOnDown | output | 1 | 1 = fire on down-count match, 0 = on up-count match |
| done | output | 1 | One-cycle result-valid flag |

## Verification
The assertions assume that `start` is a level sampled at clock edges and that all data inputs are stable around the capturing edge. The bench meets this by changing inputs only on falling edges. The selection check assumes `allShunts` is also stable around each edge.

Random stimulus from a fixed seed covers the full 16-bit range on every input, so sums past 16 bits and wrapped results occur. Directed cases force equal averages, exact equality between active and pending plus dead-band, and the unused mid-phase code.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef struct packed {
    logic load;
  } trigStrobe_t;
endpackage

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output trigStrobe_t strobe,
  output logic        done
);
  always_comb strobe.load = start;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else       done <= start;
  end

  // R9: flag follows a strobe and only a strobe
  a_r9_done_after_start: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);
  a_r9_done_needs_start: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(start));
endmodule

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int W   = 16,
  parameter int NPH = 3,
  localparam int SELW = (NPH > 1) ? $clog2(NPH) : 1,
  localparam int SW   = W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  trigStrobe_t             strobe,
  input  logic                    allShunts,
  input  logic [SELW-1:0]         midPhase,
  input  logic [NPH-1:0][W-1:0]   pendCmp,
  input  logic [NPH-1:0][W-1:0]   actCmp,
  input  logic [W-1:0]            deadFall,
  output logic [W-1:0]            cmpB,
  output logic                    socOnDown
);
  logic [W-1:0]    avg [NPH];
  logic [SELW-1:0] refIdx;
  logic [SW-1:0]   limit, actX, gap;
  logic            goDown;
  logic [W-1:0]    cmpNext;

  for (genvar g = 0; g < NPH; g++) begin : gAvg
    logic [SW-1:0] pairSum;
    assign pairSum = {1'b0, pendCmp[g]} + {1'b0, actCmp[g]};
    assign avg[g]  = W'(pairSum >> 1);
  end

  always_comb begin
    refIdx = '0;
    if (allShunts) begin
      for (int i = 1; i < NPH; i++)
        if (avg[i] < avg[refIdx]) refIdx = SELW'(i);
    end else if ({1'b0, midPhase} < (SELW+1)'(NPH)) begin
      refIdx = midPhase;
    end else begin
      refIdx = SELW'(NPH - 1);
    end
  end

  assign limit   = {1'b0, pendCmp[refIdx]} + {1'b0, deadFall};
  assign actX    = {1'b0, actCmp[refIdx]};
  assign goDown  = (actX >= limit);
  assign gap     = goDown ? (actX - limit) : (limit - actX);
  assign cmpNext = W'((gap >> 1) + SW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpB      <= '0;
      socOnDown <= 1'b0;
    end else if (strobe.load) begin
      cmpB      <= cmpNext;
      socOnDown <= goDown;
    end
  end

  // R3: the chosen phase never has a longer estimate than any other
  for (genvar g = 0; g < NPH; g++) begin : gMinChk
    a_r3_min_pick: assert property (@(posedge clk) disable iff (!rstN)
      allShunts |-> (avg[refIdx] <= avg[g]));
  end

  // R5: a down-count result is half a 16-bit gap plus one
  a_r5_down_range: assert property (@(posedge clk) disable iff (!rstN)
    socOnDown |-> (cmpB != '0) && (cmpB <= W'(1 << (W-1))));

  // R8: without a strobe the outputs do not move
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(cmpB) && $stable(socOnDown));
endmodule

// File: rtl/adc_trig_calc.sv
module adc_trig_calc
  import trig_pkg::*;
#(
  parameter int W   = 16,
  parameter int NPH = 3,
  localparam int SELW = (NPH > 1) ? $clog2(NPH) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  allShunts,
  input  logic [SELW-1:0]       midPhase,
  input  logic [NPH-1:0][W-1:0] pendCmp,
  input  logic [NPH-1:0][W-1:0] actCmp,
  input  logic [W-1:0]          deadFall,
  output logic [W-1:0]          cmpB,
  output logic                  socOnDown,
  output logic                  done
);
  trigStrobe_t strobe;

  trig_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .strobe(strobe), .done(done)
  );

  trig_datapath #(.W(W), .NPH(NPH)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .allShunts(allShunts),
    .midPhase(midPhase), .pendCmp(pendCmp), .actCmp(actCmp),
    .deadFall(deadFall), .cmpB(cmpB), .socOnDown(socOnDown)
  );
endmodule

// File: tb/sim_adc_trig_calc.sv
module sim_adc_trig_calc;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, allShunts = 1'b0;
  logic [1:0] midPhase = '0;
  logic [2:0][15:0] pendCmp = '0, actCmp = '0;
  logic [15:0] deadFall = '0;
  logic [15:0] cmpB;
  logic socOnDown, done;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_trig_calc u0 (
    .clk(clk), .rstN(rstN), .start(start), .allShunts(allShunts),
    .midPhase(midPhase), .pendCmp(pendCmp), .actCmp(actCmp),
    .deadFall(deadFall), .cmpB(cmpB), .socOnDown(socOnDown), .done(done)
  );

  function automatic int pickRef();
    int r = 0;
    logic [15:0] e [3];
    for (int i = 0; i < 3; i++) e[i] = 16'((17'(pendCmp[i]) + 17'(actCmp[i])) / 2);
    if (allShunts) begin
      for (int i = 1; i < 3; i++) if (e[i] < e[r]) r = i;
    end else r = (midPhase >= 2) ? 2 : int'(midPhase);
    return r;
  endfunction

  function automatic void model(output logic [15:0] eCmp, output logic eDown);
    int r = pickRef();
    int lim = int'(pendCmp[r]) + int'(deadFall);
    int a = int'(actCmp[r]);
    eDown = (a >= lim);
    eCmp = eDown ? 16'((a - lim) / 2 + 1) : 16'((lim - a) / 2 + 1);
  endfunction

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runOne(string req);
    logic [15:0] eCmp; logic eDown;
    model(eCmp, eDown);
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    check({req, " cmpB"}, cmpB, eCmp);
    check({req, " dir"}, socOnDown, eDown);
    check("R9 done high", done, 1);
    // R8: scramble inputs without strobe, result must hold
    pendCmp = {$urandom, $urandom}; actCmp = {$urandom, $urandom};
    deadFall = 16'($urandom); allShunts = ~allShunts;
    @(posedge clk); @(negedge clk);
    check("R8 hold cmpB", cmpB, eCmp);
    check("R8 hold dir", socOnDown, eDown);
    check("R9 done low", done, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    check("R1 cmpB", cmpB, 0);
    check("R1 dir", socOnDown, 0);
    check("R1 done", done, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 tie: all averages equal, phase 1 wins; phase 1 differs in outcome
    allShunts = 1; deadFall = 10;
    pendCmp = {16'd100, 16'd100, 16'd300}; actCmp = {16'd300, 16'd300, 16'd100};
    runOne("R3 tie1");
    allShunts = 1; deadFall = 0;
    pendCmp = {16'd50, 16'd20, 16'd900}; actCmp = {16'd51, 16'd81, 16'd900};
    runOne("R3 tie2"); // R2 truncation: 50 and 50
    // R4 each code, code 3 -> phase 3
    for (int c = 0; c < 4; c++) begin
      allShunts = 0; midPhase = 2'(c); deadFall = 5;
      pendCmp = {16'd1000, 16'd200, 16'd40}; actCmp = {16'd10, 16'd900, 16'd400};
      runOne("R4 mid");
    end
    // R5 exact equality fires down with cmpB=1
    allShunts = 0; midPhase = 0; deadFall = 7;
    pendCmp = {16'd0, 16'd0, 16'd93}; actCmp = {16'd0, 16'd0, 16'd100};
    runOne("R5 equal");
    // R6/R7 carry past 16 bits and wrap of result
    allShunts = 0; midPhase = 1; deadFall = 16'hFFFF;
    pendCmp = {16'd0, 16'hFFFF, 16'd0}; actCmp = {16'd0, 16'd0, 16'd0};
    runOne("R7 carry wrap");
    allShunts = 0; midPhase = 2; deadFall = 16'h8000;
    pendCmp = {16'h9000, 16'd0, 16'd0}; actCmp = {16'hFFFF, 16'd0, 16'd0};
    runOne("R7 carry up");

    for (int n = 0; n < 300; n++) begin
      allShunts = 1'($urandom); midPhase = 2'($urandom);
      pendCmp = {$urandom, $urandom}; actCmp = {$urandom, $urandom};
      deadFall = 16'($urandom % ((n % 3 == 0) ? 65536 : 200));
      runOne((n % 2 == 0) ? "R5/R6 rand" : "R2/R3/R4 rand");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule